// File: doc/BRIEF.md
# E3 Transmit Payload Timing Generator

This block is the serial payload entry point of a loop-timed E3 transmitter. A single bit clock, taken from the recovered receive line clock and nominally 34.368 MHz, is shared with the attached terminal equipment. The block keeps a bit-position counter that steps once per clock through a 1536-position outbound frame. Positions 0 to 11 carry overhead and positions 12 to 1535 carry payload.

The source is not given a ready/valid handshake. Instead it gets two timing pulses. The end-of-frame pulse is high while the last position of a frame is processed. The overhead warning is high in the cycle before every overhead position, so the source can hold its next payload bit for one clock. Because the overhead positions are back to back, the warning stays high from position 1535 through position 10.

On every rising edge the serial input is sampled. At payload positions the sampled bit is handed to the framer core one cycle later with a one-cycle valid strobe. A frame counter advances each time the position counter wraps.

Top module: `e3tx_payload_timer`

## Requirements
- R1: While `rst` is high (synchronous, active high), `frame_last_o`, `oh_warn_o` and `pay_valid_o` are 0 and `frame_cnt_o` is 0; the first cycle after release processes position 0.
- R2: The position advances by one per clock and wraps from 1535 to 0, so `frame_last_o` pulses exactly every 1536 cycles.
- R3: `frame_last_o` is 1 in the cycle that processes position 1535 and 0 in every other cycle.
- R4: `oh_warn_o` is 1 in the cycles that process positions 1535 and 0 to 10 (each cycle before an overhead position 0 to 11), and 0 at positions 11 to 1534.
- R5: When the cycle processing a payload position (12 to 1535) ends, `serial_in` is sampled at that rising edge; in the next cycle `pay_valid_o` is 1 and `pay_data_o` equals the sampled bit.
- R6: At overhead positions (0 to 11), `serial_in` is ignored: `pay_valid_o` is 0 in the cycle after each of them, so each full frame delivers exactly 1524 valid strobes.
- R7: `frame_cnt_o` increases by one on each wrap from position 1535 to 0; the new value is visible in the cycle of position 0 and is otherwise unchanged.
- R8: A reset asserted in the middle of a frame returns the block to position 0 with `frame_cnt_o` at 0, so the next `frame_last_o` follows 1535 cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock shared with the terminal equipment |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial payload bit from the terminal equipment |
| frame_last_o | output | 1 | High while the last frame position is processed |
| oh_warn_o | output | 1 | High one cycle before each overhead position |
| pay_data_o | output | 1 | Captured payload bit for the framer core |
| pay_valid_o | output | 1 | One-cycle strobe qualifying `pay_data_o` |
| frame_cnt_o | output | FCNT_W (16) | Number of completed frames since reset |

## Verification
The hardest condition to reach from the ports is the seam between frames: the last payload capture, the end-of-frame pulse, the counter increment, and the overhead warning that spans two frames all meet within one or two cycles. They can only be reached by clocking through the whole frame. The bench streams complete frames with pseudo-random, all-ones and alternating bit patterns. It compares every output in every cycle against a model of the position counter. A reset asserted partway through a frame checks that the position counter restarts from zero rather than resuming.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;

    typedef enum logic {
        SLOT_OVERHEAD = 1'b0,
        SLOT_PAYLOAD  = 1'b1
    } slot_kind_e;

    typedef struct packed {
        logic       last;   // final position of the frame
        logic       warn;   // next position is overhead
        slot_kind_e kind;   // class of the current position
    } slot_info_t;

endpackage

// File: rtl/e3tx_bit_counter.sv
module e3tx_bit_counter #(
    parameter int FRAME_LEN = 1536,
    localparam int POS_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pos == LAST_POS) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign wrap_o = (st_q.pos == LAST_POS);

    // R2: position never leaves the frame
    p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
        pos_o <= LAST_POS);

    // R2: wrap is followed by position 0
    p_pos_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (pos_o == '0));

    // R2: without wrap the position grows
    p_pos_grow_r2: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> (pos_o > $past(pos_o)));

endmodule

// File: rtl/e3tx_slot_decode.sv
module e3tx_slot_decode
    import e3tx_pkg::*;
#(
    parameter int FRAME_LEN = 1536,
    parameter int OH_LEN    = 12,
    localparam int POS_W = $clog2(FRAME_LEN)
) (
    input  logic [POS_W-1:0] pos_i,
    output slot_info_t       info_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] OH_END   = POS_W'(OH_LEN);
    localparam logic [POS_W-1:0] WARN_END = POS_W'(OH_LEN - 1);

    always_comb begin
        info_o      = '0;
        info_o.last = (pos_i == LAST_POS);
        info_o.kind = (pos_i < OH_END) ? SLOT_OVERHEAD : SLOT_PAYLOAD;
        // warn covers the position before every overhead slot
        info_o.warn = (pos_i == LAST_POS) || (pos_i < WARN_END);
    end

endmodule

// File: rtl/e3tx_payload_capture.sv
module e3tx_payload_capture (
    input  logic clk,
    input  logic rst,
    input  logic ser_i,
    input  logic take_i,
    output logic data_o,
    output logic valid_o
);
    typedef struct packed {
        logic data;
        logic valid;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = take_i;
        if (take_i) begin
            st_d.data = ser_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    // R5: a payload slot yields the sampled bit next cycle
    p_take_bit_r5: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (valid_o && (data_o == $past(ser_i))));

    // R6: no strobe after a skipped slot
    p_skip_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> !valid_o);

endmodule

// File: rtl/e3tx_frame_tally.sv
module e3tx_frame_tally #(
    parameter int FCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    output logic [FCNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [FCNT_W-1:0] cnt;
    } tally_state_t;

    tally_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R7: one step per wrap
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R7: steady between wraps
    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(cnt_o));

endmodule

// File: rtl/e3tx_payload_timer.sv
module e3tx_payload_timer
    import e3tx_pkg::*;
#(
    parameter int FRAME_LEN = 1536,
    parameter int OH_LEN    = 12,
    parameter int FCNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_in,
    output logic              frame_last_o,
    output logic              oh_warn_o,
    output logic              pay_data_o,
    output logic              pay_valid_o,
    output logic [FCNT_W-1:0] frame_cnt_o
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] OH_END = POS_W'(OH_LEN);

    logic [POS_W-1:0] pos_q;
    logic             wrap;
    slot_info_t       info;

    e3tx_bit_counter #(
        .FRAME_LEN (FRAME_LEN)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .pos_o  (pos_q),
        .wrap_o (wrap)
    );

    e3tx_slot_decode #(
        .FRAME_LEN (FRAME_LEN),
        .OH_LEN    (OH_LEN)
    ) u_decode (
        .pos_i  (pos_q),
        .info_o (info)
    );

    e3tx_payload_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .ser_i   (serial_in),
        .take_i  (info.kind == SLOT_PAYLOAD),
        .data_o  (pay_data_o),
        .valid_o (pay_valid_o)
    );

    e3tx_frame_tally #(
        .FCNT_W (FCNT_W)
    ) u_tally (
        .clk    (clk),
        .rst    (rst),
        .wrap_i (wrap),
        .cnt_o  (frame_cnt_o)
    );

    // pulses are silent while reset is held
    assign frame_last_o = info.last & ~rst;
    assign oh_warn_o    = info.warn & ~rst;

    // R3: a single-cycle pulse, then position 0
    p_last_single_r3: assert property (@(posedge clk) disable iff (rst)
        frame_last_o |=> (!frame_last_o && (pos_q == '0)));

    // R4: warning is always followed by an overhead slot
    p_warn_then_oh_r4: assert property (@(posedge clk) disable iff (rst)
        oh_warn_o |=> (pos_q < OH_END));

    // R4: every overhead slot after the first was announced
    p_oh_announced_r4: assert property (@(posedge clk) disable iff (rst)
        ((pos_q != '0) && (pos_q < OH_END)) |-> $past(oh_warn_o));

    // R6: no strobe in the cycle after overhead positions 0..OH_LEN-1
    p_no_oh_valid_r6: assert property (@(posedge clk) disable iff (rst)
        pay_valid_o |-> !((pos_q != '0) && (pos_q <= OH_END)));

endmodule

// File: tb/tb_e3tx_payload_timer.sv
module tb_e3tx_payload_timer;
    localparam int FRAME_LEN = 1536;
    localparam int OH_LEN    = 12;
    localparam int FCNT_W    = 16;
    localparam int LAST      = FRAME_LEN - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              serial_in = 1'b0;
    logic              frame_last_o;
    logic              oh_warn_o;
    logic              pay_data_o;
    logic              pay_valid_o;
    logic [FCNT_W-1:0] frame_cnt_o;

    e3tx_payload_timer #(
        .FRAME_LEN (FRAME_LEN),
        .OH_LEN    (OH_LEN),
        .FCNT_W    (FCNT_W)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .serial_in    (serial_in),
        .frame_last_o (frame_last_o),
        .oh_warn_o    (oh_warn_o),
        .pay_data_o   (pay_data_o),
        .pay_valid_o  (pay_valid_o),
        .frame_cnt_o  (frame_cnt_o)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state for the current cycle
    int          pos_m;
    int unsigned cnt_m;
    logic        exp_v, exp_d;
    logic        prev_oh;
    logic [15:0] lfsr = 16'hACE1;
    int          since_rst, first_last, prev_last, valid_run;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic pick_bit(input int mode, input int idx);
        case (mode)
            1:       return 1'b1;
            2:       return idx[0];
            default: return lfsr[0];
        endcase
    endfunction

    // hold reset for a few edges, check quiet outputs, release
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({tag, " frame_last in reset"}, 32'(frame_last_o), 32'd0);
        chk({tag, " oh_warn in reset"},    32'(oh_warn_o),    32'd0);
        chk({tag, " pay_valid in reset"},  32'(pay_valid_o),  32'd0);
        chk({tag, " frame_cnt in reset"},  32'(frame_cnt_o),  32'd0);
        rst = 1'b0;
        pos_m = 0; cnt_m = 0; exp_v = 1'b0; exp_d = 1'b0; prev_oh = 1'b1;
        since_rst = 0; first_last = -1; prev_last = -1; valid_run = 0;
        #1;
    endtask

    // compare every output each cycle against the model
    task automatic run_stream(input int cycles, input int mode);
        for (int i = 0; i < cycles; i++) begin
            logic b;
            chk("R3 frame_last", 32'(frame_last_o), 32'(pos_m == LAST));
            chk("R4 oh_warn", 32'(oh_warn_o), 32'((pos_m == LAST) || (pos_m < OH_LEN - 1)));
            chk(prev_oh ? "R6 pay_valid after overhead" : "R5 pay_valid after payload",
                32'(pay_valid_o), 32'(exp_v));
            if (exp_v) chk("R5 pay_data", 32'(pay_data_o), 32'(exp_d));
            chk("R7 frame_cnt", 32'(frame_cnt_o), cnt_m & 32'hFFFF);
            if (pay_valid_o) valid_run++;
            if (frame_last_o) begin
                if (first_last < 0) first_last = since_rst;
                if (prev_last >= 0) begin
                    chk("R2 pulse spacing", 32'(since_rst - prev_last), 32'(FRAME_LEN));
                    chk("R6 strobes per frame", 32'(valid_run), 32'(FRAME_LEN - OH_LEN));
                end
                prev_last = since_rst;
                valid_run = 0;
            end
            b = pick_bit(mode, i);
            serial_in = b;
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            exp_v   = (pos_m >= OH_LEN);
            exp_d   = b;
            prev_oh = (pos_m < OH_LEN);
            if (pos_m == LAST) begin
                cnt_m++;
                pos_m = 0;
            end else begin
                pos_m++;
            end
            since_rst++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset("R1");
        chk("R1 first cycle warns for position 1", 32'(oh_warn_o), 32'd1);
        chk("R1 first cycle not frame end", 32'(frame_last_o), 32'd0);
    endtask

    task automatic t_random_frames();
        run_stream(3 * FRAME_LEN + 20, 0);
        chk("R2 first frame end after release", 32'(first_last), 32'(LAST));
        chk("R7 frames counted", 32'(frame_cnt_o), 32'd3);
    endtask

    task automatic t_ones_frame();
        run_stream(FRAME_LEN, 1);
    endtask

    task automatic t_alternating_frame();
        run_stream(FRAME_LEN, 2);
    endtask

    task automatic t_mid_reset();
        run_stream(700, 0);
        do_reset("R8");
        run_stream(2 * FRAME_LEN, 0);
        chk("R8 frame end position after mid-frame reset", 32'(first_last), 32'(LAST));
        chk("R8 count restarted", 32'(frame_cnt_o), 32'd2);
    endtask

    initial begin
        t_reset_state();
        t_random_frames();
        t_ones_frame();
        t_alternating_frame();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule